// File: doc/BRIEF.md
# USART Bit Clock Generator

This block derives the bit timing of a serial port from a single system clock. In asynchronous mode a reloadable divider produces an oversampling tick. Phase counters turn that tick into a transmit shift strobe and a mid-bit receive sample strobe. The receive phase realigns on each falling edge of the receive line. A double-speed control shortens the bit from sixteen ticks to eight.

In synchronous mode the bit clock is carried on a separate serial clock line. As master, the block toggles its own clock output on every divider tick. As slave, it resynchronizes an external clock and detects its edges. A polarity input picks which clock edge changes transmit data; the opposite edge samples receive data. All outputs are single-cycle strobes for a shift register, framer and buffer that live elsewhere.

Top module: `usart_clkgen`

## Requirements
- R1: While reset is asserted, all three strobes and `xck_o` are 0.
- R2: The divider emits a tick every `baud_div_i`+1 system cycles. The first tick comes on the first cycle after reset is released. A new setting takes effect at the next reload. In asynchronous mode `rx_os_tick_o` equals this tick.
- R3: In asynchronous mode with double speed off, `tx_shift_o` fires on every 16th tick. Its tick phase counter starts at 0 after reset, and the strobe marks phase 0.
- R4: In asynchronous mode with double speed on, the bit is 8 ticks. The transmit phase wraps after 8 ticks. The receive sample falls on the 4th tick after realignment instead of the 8th.
- R5: The receive line passes through two synchronizer stages. A falling edge seen there resets the receive phase. `rx_sample_o` fires on the 8th tick after that edge when double speed is off. A tick in the same cycle as the edge is not counted and gives no sample.
- R6: In synchronous master mode, `xck_o` starts at 0 and toggles on each tick, so its period is 2×(`baud_div_i`+1) cycles. In every other mode `xck_o` is 0.
- R7: In synchronous slave mode, a change of `xck_i` yields its edge strobe two system cycles after the clock edge that first captures it.
- R8: In synchronous modes with polarity 0, `tx_shift_o` marks rising clock edges and `rx_sample_o` marks falling edges. With polarity 1 the two are swapped. In master mode each strobe appears in the first cycle that `xck_o` shows the new level.
- R9: In synchronous modes the double-speed input has no effect on any output.
- R10: In synchronous modes `rx_os_tick_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1 selects synchronous operation |
| slave_i | input | 1 | In synchronous mode, 1 takes the clock from `xck_i` |
| dbl_speed_i | input | 1 | Asynchronous double speed (8 ticks per bit) |
| pol_i | input | 1 | Serial clock polarity select |
| baud_div_i | input | 12 | Divider setting; divisor is setting plus one |
| xck_i | input | 1 | External serial clock (slave mode) |
| rxd_i | input | 1 | Receive line, used for phase realignment |
| xck_o | output | 1 | Generated serial clock (master mode) |
| tx_shift_o | output | 1 | Transmit shift strobe |
| rx_sample_o | output | 1 | Receive sample strobe |
| rx_os_tick_o | output | 1 | Receiver oversampling tick |

## Verification
Two events can fall in the same cycle. One is a falling edge on the synchronized receive line. The other is the divider tick that would otherwise advance the receive phase or produce the mid-bit sample. The bench holds the line high for a stretch that grows by one cycle per trial, then pulls it low. The edge thus lands on every offset of the divider period, including the exact tick cycle and the cycle of a pending sample. A behavioural model compares every cycle that the edge wins: the phase restarts and no sample is given. It also checks that the sample appears exactly eight ticks later.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;
  localparam int unsigned DIV_W   = 12;
  localparam int unsigned OS_NORM = 16;
  localparam int unsigned OS_FAST = 8;
  localparam int unsigned SYNC_ST = 2;

  typedef enum logic [1:0] {
    MODE_ASYNC  = 2'd0,
    MODE_MASTER = 2'd1,
    MODE_SLAVE  = 2'd2
  } clk_mode_e;
endpackage

// File: rtl/ucg_baud_div.sv
module ucg_baud_div #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= div_i;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/ucg_sync.sv
module ucg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic cur_o,
  output logic prv_o
);
  logic [STAGES:0] sh_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sh_q[g] <= 1'b0;
      else if (g == 0) sh_q[g] <= d_i;
      else             sh_q[g] <= sh_q[(g == 0) ? 0 : g-1];
    end
  end

  // last synchronized stage and one extra copy for edge detection
  assign cur_o = sh_q[STAGES-1];
  assign prv_o = sh_q[STAGES];
endmodule

// File: rtl/ucg_async_phase.sv
module ucg_async_phase #(
  parameter int unsigned OS_NORM = 16,
  parameter int unsigned OS_FAST = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fast_i,
  input  logic fall_i,
  output logic tx_shift_o,
  output logic rx_sample_o
);
  localparam int unsigned PH_W = $clog2(OS_NORM);
  localparam logic [PH_W-1:0] LAST_N = PH_W'(OS_NORM - 1);
  localparam logic [PH_W-1:0] LAST_F = PH_W'(OS_FAST - 1);
  localparam logic [PH_W-1:0] MID_N  = PH_W'(OS_NORM / 2 - 1);
  localparam logic [PH_W-1:0] MID_F  = PH_W'(OS_FAST / 2 - 1);

  logic [PH_W-1:0] tx_ph_q, rx_ph_q, last, mid;

  assign last = fast_i ? LAST_F : LAST_N;
  assign mid  = fast_i ? MID_F  : MID_N;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ph_q <= '0;
      rx_ph_q <= '0;
    end else begin
      if (tick_i) tx_ph_q <= (tx_ph_q >= last) ? '0 : tx_ph_q + 1'b1;
      // start edge realigns; a coincident tick is dropped
      if (fall_i)      rx_ph_q <= '0;
      else if (tick_i) rx_ph_q <= (rx_ph_q >= last) ? '0 : rx_ph_q + 1'b1;
    end
  end

  assign tx_shift_o  = tick_i && (tx_ph_q == '0);
  assign rx_sample_o = tick_i && !fall_i && (rx_ph_q == mid);
endmodule

// File: rtl/ucg_xck_gen.sv
module ucg_xck_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic xck_o,
  output logic rise_o,
  output logic fall_o
);
  logic xck_q, xck_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xck_q   <= 1'b0;
      xck_d_q <= 1'b0;
    end else begin
      xck_d_q <= xck_q;
      if (!en_i)       xck_q <= 1'b0;
      else if (tick_i) xck_q <= ~xck_q;
    end
  end

  assign xck_o  = xck_q;
  assign rise_o = xck_q & ~xck_d_q;
  assign fall_o = ~xck_q & xck_d_q;
endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
  import usart_clkgen_pkg::*;
#(
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_mode_i,
  input  logic          slave_i,
  input  logic          dbl_speed_i,
  input  logic          pol_i,
  input  logic [DW-1:0] baud_div_i,
  input  logic          xck_i,
  input  logic          rxd_i,
  output logic          xck_o,
  output logic          tx_shift_o,
  output logic          rx_sample_o,
  output logic          rx_os_tick_o
);
  clk_mode_e mode;
  logic tick, fast;
  logic rx_cur, rx_prv, rx_fall;
  logic xi_cur, xi_prv;
  logic m_xck, m_rise, m_fall;
  logic e_rise, e_fall, chg, smp;
  logic a_tx, a_rx;

  always_comb begin
    if (!sync_mode_i) mode = MODE_ASYNC;
    else if (slave_i) mode = MODE_SLAVE;
    else              mode = MODE_MASTER;
  end

  assign fast = dbl_speed_i && (mode == MODE_ASYNC);

  ucg_baud_div #(.W(DW)) i_div (
    .clk_i, .rst_ni, .div_i(baud_div_i), .tick_o(tick)
  );

  ucg_sync #(.STAGES(SYNC_ST)) i_rx_sync (
    .clk_i, .rst_ni, .d_i(rxd_i), .cur_o(rx_cur), .prv_o(rx_prv)
  );
  assign rx_fall = rx_prv & ~rx_cur;

  ucg_sync #(.STAGES(SYNC_ST)) i_xck_sync (
    .clk_i, .rst_ni, .d_i(xck_i), .cur_o(xi_cur), .prv_o(xi_prv)
  );

  ucg_async_phase #(.OS_NORM(OS_NORM), .OS_FAST(OS_FAST)) i_phase (
    .clk_i, .rst_ni, .tick_i(tick), .fast_i(fast), .fall_i(rx_fall),
    .tx_shift_o(a_tx), .rx_sample_o(a_rx)
  );

  ucg_xck_gen i_xgen (
    .clk_i, .rst_ni, .en_i(mode == MODE_MASTER), .tick_i(tick),
    .xck_o(m_xck), .rise_o(m_rise), .fall_o(m_fall)
  );

  always_comb begin
    e_rise = (mode == MODE_SLAVE) ? (xi_cur & ~xi_prv) : m_rise;
    e_fall = (mode == MODE_SLAVE) ? (xi_prv & ~xi_cur) : m_fall;
    chg    = pol_i ? e_fall : e_rise;
    smp    = pol_i ? e_rise : e_fall;
  end

  assign xck_o        = (mode == MODE_MASTER) && m_xck;
  assign tx_shift_o   = (mode == MODE_ASYNC) ? a_tx : chg;
  assign rx_sample_o  = (mode == MODE_ASYNC) ? a_rx : smp;
  assign rx_os_tick_o = (mode == MODE_ASYNC) && tick;
endmodule

// File: rtl/usart_clkgen_chk.sv
module usart_clkgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sync_mode_i,
  input logic slave_i,
  input logic pol_i,
  input logic xck_i,
  input logic xck_o,
  input logic tx_shift_o,
  input logic rx_sample_o,
  input logic rx_os_tick_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !(tx_shift_o || rx_sample_o || rx_os_tick_o || xck_o)); // R1

  AST_ASYNC_SHIFT_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_mode_i && tx_shift_o) |-> rx_os_tick_o); // R3

  AST_XCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_mode_i && !slave_i) |-> !xck_o); // R6

  AST_SLAVE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && slave_i && !pol_i && tx_shift_o) |-> $past(xck_i, 2)); // R7

  AST_MASTER_EDGE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && !slave_i && !pol_i && tx_shift_o) |-> xck_o); // R8

  AST_SYNC_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_mode_i |-> !(tx_shift_o && rx_sample_o)); // R8

  AST_NO_OS_TICK_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_mode_i |-> !rx_os_tick_o); // R10
endmodule

bind usart_clkgen usart_clkgen_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_mode_i(sync_mode_i), .slave_i(slave_i),
  .pol_i(pol_i), .xck_i(xck_i), .xck_o(xck_o), .tx_shift_o(tx_shift_o),
  .rx_sample_o(rx_sample_o), .rx_os_tick_o(rx_os_tick_o)
);

// File: tb/test_usart_clkgen.sv
module test_usart_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sync_mode = 1'b0, slave = 1'b0, dbl = 1'b0, pol = 1'b0;
  logic [DW-1:0] div = 12'd3;
  logic xck_in = 1'b0, rxd = 1'b1;
  logic xck_out, tx_shift, rx_sample, os_tick;

  int n_chk = 0, n_err = 0;

  usart_clkgen i_usart_clkgen (
    .clk_i(clk), .rst_ni(rst_ni), .sync_mode_i(sync_mode), .slave_i(slave),
    .dbl_speed_i(dbl), .pol_i(pol), .baud_div_i(div), .xck_i(xck_in),
    .rxd_i(rxd), .xck_o(xck_out), .tx_shift_o(tx_shift),
    .rx_sample_o(rx_sample), .rx_os_tick_o(os_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference state
  int m_cnt, m_tx_ph, m_rx_ph;
  bit m_tick, m_x, m_xd;
  bit rq[$];
  bit xq[$];

  function automatic void model_reset();
    m_cnt = 0; m_tx_ph = 0; m_rx_ph = 0; m_tick = 0; m_x = 0; m_xd = 0;
    rq = '{0, 0, 0};
    xq = '{0, 0, 0};
  endfunction

  initial model_reset();

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) model_reset();
    else begin
      int  bits;
      bit  fall;
      bit  master;
      bits   = (dbl && !sync_mode) ? 8 : 16;
      fall   = rq[2] && !rq[1];
      master = sync_mode && !slave;
      if (m_tick) m_tx_ph = (m_tx_ph + 1 >= bits) ? 0 : m_tx_ph + 1;
      if (fall) m_rx_ph = 0;
      else if (m_tick) m_rx_ph = (m_rx_ph + 1 >= bits) ? 0 : m_rx_ph + 1;
      m_xd = m_x;
      if (!master) m_x = 0;
      else if (m_tick) m_x = !m_x;
      m_tick = (m_cnt == 0);
      m_cnt  = (m_cnt == 0) ? int'(div) : m_cnt - 1;
      rq.push_front(rxd); void'(rq.pop_back());
      xq.push_front(xck_in); void'(xq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      int  bits;
      bit  fall, e_r, e_f, e_tx, e_rx, e_os, e_x;
      string ttag, rtag, otag;
      bits = dbl ? 8 : 16;
      fall = rq[2] && !rq[1];
      if (!sync_mode) begin
        e_tx = m_tick && m_tx_ph == 0;
        e_rx = m_tick && !fall && m_rx_ph == bits/2 - 1;
        e_os = m_tick;
        e_x  = 0;
        ttag = dbl ? "R4" : "R3";
        rtag = dbl ? "R4" : "R5";
        otag = "R2";
      end else begin
        if (slave) begin e_r = xq[1] && !xq[2]; e_f = !xq[1] && xq[2]; end
        else       begin e_r = m_x && !m_xd;    e_f = !m_x && m_xd;    end
        e_tx = pol ? e_f : e_r;
        e_rx = pol ? e_r : e_f;
        e_os = 0;
        e_x  = slave ? 0 : m_x;
        ttag = dbl ? "R9" : (slave ? "R7" : "R8");
        rtag = dbl ? "R9" : "R8";
        otag = "R10";
      end
      chk(ttag, tx_shift, e_tx);
      chk(rtag, rx_sample, e_rx);
      chk(otag, os_tick, e_os);
      chk("R6", xck_out, e_x);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet under reset
    chk("R1", tx_shift, 1'b0);
    chk("R1", rx_sample, 1'b0);
    chk("R1", os_tick, 1'b0);
    chk("R1", xck_out, 1'b0);
    step(); rst_ni = 1'b1;

    // async, normal speed
    for (int i = 0; i < 400; i++) begin rxd = ((i * 7) % 23) > 5; step(); end
    // async, double speed
    dbl = 1'b1; div = 12'd1;
    for (int i = 0; i < 300; i++) begin rxd = ((i * 5) % 19) > 4; step(); end
    // divisor zero: tick every cycle
    dbl = 1'b0; div = 12'd0;
    for (int i = 0; i < 200; i++) begin rxd = ((i * 3) % 41) > 8; step(); end
    // start edge swept across the divider period
    div = 12'd2;
    for (int k = 0; k < 12; k++) begin
      rxd = 1'b1; repeat (40 + k) step();
      rxd = 1'b0; repeat (60) step();
    end
    dbl = 1'b1;
    for (int k = 0; k < 6; k++) begin
      rxd = 1'b1; repeat (30 + k) step();
      rxd = 1'b0; repeat (40) step();
    end
    // synchronous master
    sync_mode = 1'b1; slave = 1'b0; pol = 1'b0; dbl = 1'b0; div = 12'd2;
    repeat (150) step();
    pol = 1'b1; repeat (150) step();
    dbl = 1'b1; repeat (100) step();
    // synchronous slave
    slave = 1'b1; pol = 1'b0; dbl = 1'b0;
    for (int i = 0; i < 200; i++) begin if (i % 3 == 0) xck_in = ~xck_in; step(); end
    pol = 1'b1;
    for (int i = 0; i < 200; i++) begin if (i % 5 == 0) xck_in = ~xck_in; step(); end
    dbl = 1'b1;
    for (int i = 0; i < 100; i++) begin if (i % 4 == 0) xck_in = ~xck_in; step(); end
    // back to async
    sync_mode = 1'b0; slave = 1'b0; dbl = 1'b0; div = 12'd3;
    for (int i = 0; i < 200; i++) begin rxd = ((i * 11) % 29) > 6; step(); end
    @(negedge clk);
    finish_run();
  end
endmodule